// File: doc/BRIEF.md
# Board System Configuration Register Block

This block is a 32-bit register bank for a board-level system controller, reached over a simple word-addressed bus with separate read and write strobes. Read data is registered and appears one cycle after the read strobe. Most of its registers are direct: an LED output register, a DLL status word with a writable mask, a DIP-switch word that reads as zero, and three identification words whose values are fixed by parameters.

The indirect part is a configuration channel to a small bank of oscillator-frequency registers. Software places a value in the outgoing-data register, then writes a control word that holds a device number, a function code, a direction flag and a start flag. A start finishes in the same cycle as the control write. A write-direction transfer copies the outgoing value into the selected oscillator register. A read-direction transfer copies the selected oscillator register into the returned-data register. A status word reports done and error. The block occupies a 4 KiB window, is little-endian and has ten word-address bits.

Top module: `sysctl_regblk`

## Requirements
- R1: After reset, control reads 0x00100000, status 0, LED 0, DLL mask 0, and oscillator registers 0, 1 and 2 hold 50000000, 24576000 and 25000000.
- R2: Read data appears on bus_rdata one cycle after bus_rd and holds until the next read. The word addresses are: LED 0x000, DIP 0x002, ID words 0x004/0x005/0x006, DLL 0x008, returned data 0x028, outgoing data 0x029, control 0x02A, status 0x02B.
- R3: A control write stores only device [11:0], function [25:20] and the write flag [30]. Bits [19:12], [29:26] and the start bit [31] read back as 0.
- R4: Every control write clears status, whose done bit is 0 and error bit is 1.
- R5: A control write with start=1, write flag=1, function 1 and device below 3 copies the outgoing-data register into that oscillator register and sets status to 1.
- R6: A control write with start=1, write flag=0, function 1 and device below 3 loads the returned-data register from that oscillator register and sets status to 1.
- R7: A started transfer whose function is not 1, or whose device is 3 or more, sets status to 3. It changes no oscillator register and leaves returned data unchanged.
- R8: Bit i of the LED register drives led_out[i] and reads back. Bits above LED_W read as 0.
- R9: The DLL word reads as {mask[7:0], dll_lock[7:0], 15'b0, all_locked}. Only bits [31:24] are writable. all_locked is 1 when every lock input whose mask bit is set is high, so it is 1 when the mask is 0.
- R10: The three ID words read their parameter values and ignore writes. The DIP word reads 0.
- R11: Reads at unmapped addresses return 0. Writes to unmapped addresses change nothing.
- R12: The outgoing-data register reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 10 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dll_lock | input | 8 | Per-DLL lock indications |
| led_out | output | LED_W | Active-high LED drives |

## Verification
A wrong oscillator value stays hidden until a read transfer to that device, and is then visible in returned data one read after the transfer. A status or control register holding a bad value shows on the next read of that word. A wrong LED state shows on led_out in the cycle after the write. The DLL summary is combinational from the lock pins and mask, so a fault there shows on the first DLL read after the lock pattern changes.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int DLL_N  = 8;

    localparam logic [ADDR_W-1:0] A_LED  = 10'h000;
    localparam logic [ADDR_W-1:0] A_DIP  = 10'h002;
    localparam logic [ADDR_W-1:0] A_IDB  = 10'h004;
    localparam logic [ADDR_W-1:0] A_IDC  = 10'h005;
    localparam logic [ADDR_W-1:0] A_IDA  = 10'h006;
    localparam logic [ADDR_W-1:0] A_DLL  = 10'h008;
    localparam logic [ADDR_W-1:0] A_RTN  = 10'h028;
    localparam logic [ADDR_W-1:0] A_DOUT = 10'h029;
    localparam logic [ADDR_W-1:0] A_CTRL = 10'h02A;
    localparam logic [ADDR_W-1:0] A_STAT = 10'h02B;

    localparam int DEV_LSB   = 0;
    localparam int DEV_W     = 12;
    localparam int FN_LSB    = 20;
    localparam int FN_W      = 6;
    localparam int WR_BIT    = 30;
    localparam int START_BIT = 31;
    localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h43F0_0FFF;
    localparam logic [DATA_W-1:0] CTRL_RST  = 32'h0010_0000;
    localparam logic [FN_W-1:0]   FN_OSC    = 6'd1;

    localparam int ST_DONE = 0;
    localparam int ST_ERR  = 1;

    localparam int MASK_LSB = 24;
    localparam int LOCK_LSB = 16;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [1:0]        stat;
        logic [DATA_W-1:0] rtn;
        logic [DATA_W-1:0] dout;
    } chan_t;
endpackage

// File: rtl/sysctl_dll_stat.sv
module sysctl_dll_stat
    import sysctl_pkg::*;
(
    input  logic [DLL_N-1:0]  lock,
    input  logic [DLL_N-1:0]  mask,
    output logic [DATA_W-1:0] word
);
    logic [DLL_N-1:0] ok_bit;

    for (genvar i = 0; i < DLL_N; i++) begin : g_ok
        assign ok_bit[i] = lock[i] | ~mask[i];
    end

    always_comb begin
        word = '0;
        word[MASK_LSB +: DLL_N] = mask;
        word[LOCK_LSB +: DLL_N] = lock;
        word[0]                 = &ok_bit;
    end
endmodule

// File: rtl/sysctl_cfg_chan.sv
module sysctl_cfg_chan
    import sysctl_pkg::*;
#(
    parameter int                      NUM_OSC = 3,
    parameter logic [NUM_OSC*32-1:0]   OSC_RST = {32'd25000000, 32'd24576000, 32'd50000000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              dout_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl,
    output logic [1:0]        stat,
    output logic [DATA_W-1:0] rtn,
    output logic [DATA_W-1:0] dout
);
    chan_t s_d, s_q;
    logic [NUM_OSC-1:0][DATA_W-1:0] osc_d, osc_q;
    logic [NUM_OSC-1:0] hit;
    logic [DEV_W-1:0]   dev;
    logic [FN_W-1:0]    fn;
    logic               legal;

    assign dev = wdata[DEV_LSB +: DEV_W];
    assign fn  = wdata[FN_LSB +: FN_W];

    for (genvar i = 0; i < NUM_OSC; i++) begin : g_hit
        assign hit[i] = (dev == DEV_W'(i));
    end

    assign legal = (fn == FN_OSC) && (|hit);

    always_comb begin
        s_d   = s_q;
        osc_d = osc_q;
        if (dout_we) begin
            s_d.dout = wdata;
        end
        if (ctrl_we) begin
            s_d.ctrl = wdata & CTRL_KEEP;
            s_d.stat = '0;
            if (wdata[START_BIT]) begin
                s_d.stat[ST_DONE] = 1'b1;
                if (!legal) begin
                    s_d.stat[ST_ERR] = 1'b1;
                end else if (wdata[WR_BIT]) begin
                    for (int i = 0; i < NUM_OSC; i++) begin
                        if (hit[i]) osc_d[i] = s_q.dout;
                    end
                end else begin
                    for (int i = 0; i < NUM_OSC; i++) begin
                        if (hit[i]) s_d.rtn = osc_q[i];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ctrl <= CTRL_RST;
            s_q.stat <= '0;
            s_q.rtn  <= '0;
            s_q.dout <= '0;
            osc_q    <= OSC_RST;
        end else begin
            s_q   <= s_d;
            osc_q <= osc_d;
        end
    end

    assign ctrl = s_q.ctrl;
    assign stat = s_q.stat;
    assign rtn  = s_q.rtn;
    assign dout = s_q.dout;
endmodule

// File: rtl/sysctl_regblk.sv
module sysctl_regblk
    import sysctl_pkg::*;
#(
    parameter int                    LED_W    = 8,
    parameter int                    NUM_OSC  = 3,
    parameter logic [NUM_OSC*32-1:0] OSC_RST  = {32'd25000000, 32'd24576000, 32'd50000000},
    parameter logic [31:0]           ID_BOARD = 32'h4104_1230,
    parameter logic [31:0]           ID_CFG   = 32'h0000_0005,
    parameter logic [31:0]           ID_AID   = 32'h0220_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [9:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [7:0]        dll_lock,
    output logic [LED_W-1:0]  led_out
);
    typedef struct packed {
        logic [LED_W-1:0]  led;
        logic [DLL_N-1:0]  mask;
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t top_d, top_q;

    logic [DATA_W-1:0] cfg_ctrl, cfg_rtn, cfg_dout, dll_word, rd_val;
    logic [1:0]        cfg_stat;
    logic [DLL_N-1:0]  dll_mask;
    logic              ctrl_we, dout_we;

    assign ctrl_we  = bus_wr && (bus_addr == A_CTRL);
    assign dout_we  = bus_wr && (bus_addr == A_DOUT);
    assign dll_mask = top_q.mask;

    sysctl_cfg_chan #(
        .NUM_OSC (NUM_OSC),
        .OSC_RST (OSC_RST)
    ) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (ctrl_we),
        .dout_we (dout_we),
        .wdata   (bus_wdata),
        .ctrl    (cfg_ctrl),
        .stat    (cfg_stat),
        .rtn     (cfg_rtn),
        .dout    (cfg_dout)
    );

    sysctl_dll_stat u_dll (
        .lock (dll_lock),
        .mask (top_q.mask),
        .word (dll_word)
    );

    always_comb begin
        rd_val = '0;
        case (bus_addr)
            A_LED:   rd_val[LED_W-1:0] = top_q.led;
            A_DIP:   rd_val = '0;
            A_IDB:   rd_val = ID_BOARD;
            A_IDC:   rd_val = ID_CFG;
            A_IDA:   rd_val = ID_AID;
            A_DLL:   rd_val = dll_word;
            A_RTN:   rd_val = cfg_rtn;
            A_DOUT:  rd_val = cfg_dout;
            A_CTRL:  rd_val = cfg_ctrl;
            A_STAT:  rd_val[1:0] = cfg_stat;
            default: rd_val = '0;
        endcase
    end

    always_comb begin
        top_d = top_q;
        if (bus_rd) begin
            top_d.rdata = rd_val;
        end
        if (bus_wr) begin
            if (bus_addr == A_LED) top_d.led  = bus_wdata[LED_W-1:0];
            if (bus_addr == A_DLL) top_d.mask = bus_wdata[MASK_LSB +: DLL_N];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign bus_rdata = top_q.rdata;
    assign led_out   = top_q.led;
endmodule

// File: rtl/sysctl_regblk_chk.sv
module sysctl_regblk_chk
    import sysctl_pkg::*;
#(
    parameter int LED_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [9:0]       bus_addr,
    input logic             bus_wr,
    input logic [31:0]      bus_wdata,
    input logic [LED_W-1:0] led_out,
    input logic [31:0]      cfg_ctrl,
    input logic [1:0]       cfg_stat,
    input logic [31:0]      cfg_rtn,
    input logic [7:0]       dll_mask,
    input logic [31:0]      dll_word
);
    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);

    assert_stat_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !bus_wdata[START_BIT]) |=> (cfg_stat == 2'b00));

    assert_start_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[START_BIT]) |=> cfg_stat[ST_DONE]);

    assert_start_not_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !cfg_ctrl[START_BIT]);

    assert_bad_fn_keeps_rtn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[START_BIT] && (bus_wdata[FN_LSB +: FN_W] != FN_OSC))
        |=> ($stable(cfg_rtn) && cfg_stat[ST_ERR]));

    assert_err_implies_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_stat[ST_ERR] |-> cfg_stat[ST_DONE]);

    assert_mask_zero_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_mask == '0) |-> dll_word[0]);

    assert_unmapped_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 10'h3FF)) |=> ($stable(led_out) && $stable(cfg_ctrl) && $stable(dll_mask)));
endmodule

bind sysctl_regblk sysctl_regblk_chk #(.LED_W(LED_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .led_out   (led_out),
    .cfg_ctrl  (cfg_ctrl),
    .cfg_stat  (cfg_stat),
    .cfg_rtn   (cfg_rtn),
    .dll_mask  (dll_mask),
    .dll_word  (dll_word)
);

// File: tb/sysctl_regblk_tb.sv
module sysctl_regblk_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  dll_lock = '0;
    logic [7:0]  led_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 0;

    always #10 clk = ~clk;

    sysctl_regblk u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dll_lock  (dll_lock),
        .led_out   (led_out)
    );

    // Behavioural reference model
    logic [31:0] m_ctrl, m_stat, m_rtn, m_dout, m_rdata;
    logic [31:0] m_osc [0:2];
    logic [7:0]  m_led, m_mask;

    function automatic logic [31:0] m_read(input logic [9:0] a);
        logic [31:0] v;
        bit all_ok;
        all_ok = 1;
        for (int i = 0; i < 8; i++) if (m_mask[i] && !dll_lock[i]) all_ok = 0;
        case (a)
            10'h000: v = {24'd0, m_led};
            10'h004: v = 32'h4104_1230;
            10'h005: v = 32'h0000_0005;
            10'h006: v = 32'h0220_0000;
            10'h008: v = {m_mask, dll_lock, 15'd0, all_ok};
            10'h028: v = m_rtn;
            10'h029: v = m_dout;
            10'h02A: v = m_ctrl;
            10'h02B: v = m_stat;
            default: v = 32'd0;
        endcase
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl <= 32'h0010_0000; m_stat <= 0; m_rtn <= 0; m_dout <= 0; m_rdata <= 0;
            m_led <= 0; m_mask <= 0;
            m_osc[0] <= 32'd50000000; m_osc[1] <= 32'd24576000; m_osc[2] <= 32'd25000000;
        end else begin
            if (bus_rd) m_rdata <= m_read(bus_addr);
            if (bus_wr) begin
                case (bus_addr)
                    10'h000: m_led <= bus_wdata[7:0];
                    10'h008: m_mask <= bus_wdata[31:24];
                    10'h029: m_dout <= bus_wdata;
                    10'h02A: begin
                        m_ctrl <= bus_wdata & 32'h43F0_0FFF;
                        if (!bus_wdata[31]) m_stat <= 0;
                        else if (bus_wdata[25:20] == 6'd1 && bus_wdata[11:0] < 12'd3) begin
                            m_stat <= 1;
                            if (bus_wdata[30]) m_osc[bus_wdata[1:0]] <= m_dout;
                            else m_rtn <= m_osc[bus_wdata[1:0]];
                        end else m_stat <= 3;
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            check("R2 rdata vs model", bus_rdata, m_rdata);
            check("R8 led_out vs model", {24'd0, led_out}, {24'd0, m_led});
        end
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [9:0] a, input logic [31:0] exp, input string req);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, exp);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk(10'h02A, 32'h0010_0000, "R1 ctrl reset");
        rd_chk(10'h02B, 32'd0, "R1 stat reset");
        rd_chk(10'h000, 32'd0, "R1 led reset");
        check("R1 led pins reset", {24'd0, led_out}, 32'd0);
        wr(10'h02A, 32'h8010_0000);
        rd_chk(10'h028, 32'd50000000, "R1 osc0 reset");
        wr(10'h02A, 32'h8010_0002);
        rd_chk(10'h028, 32'd25000000, "R1 osc2 reset");

        // R6 good read
        wr(10'h02A, 32'h8010_0001);
        rd_chk(10'h02B, 32'd1, "R6 done after read");
        rd_chk(10'h028, 32'd24576000, "R6 osc1 value");

        // R12 / R5 good write then read back
        wr(10'h029, 32'h1234_5678);
        rd_chk(10'h029, 32'h1234_5678, "R12 dout readback");
        wr(10'h02A, 32'hC010_0002);
        rd_chk(10'h02B, 32'd1, "R5 done after write");
        wr(10'h02A, 32'h8010_0002);
        rd_chk(10'h028, 32'h1234_5678, "R5 osc2 written");

        // R7 bad function
        wr(10'h02A, 32'h8020_0000);
        rd_chk(10'h02B, 32'd3, "R7 bad function status");
        rd_chk(10'h028, 32'h1234_5678, "R7 rtn unchanged");
        // R7 bad device, write direction
        wr(10'h029, 32'd999);
        wr(10'h02A, 32'hC010_0003);
        rd_chk(10'h02B, 32'd3, "R7 bad device status");
        rd_chk(10'h028, 32'h1234_5678, "R7 rtn unchanged dev");
        wr(10'h02A, 32'h8010_0000);
        rd_chk(10'h028, 32'd50000000, "R7 osc0 untouched");
        wr(10'h02A, 32'h8010_0002);
        rd_chk(10'h028, 32'h1234_5678, "R7 osc2 untouched");

        // R4 status clearing
        wr(10'h02A, 32'h0010_0001);
        rd_chk(10'h02B, 32'd0, "R4 status cleared");

        // R3 masking
        wr(10'h02A, 32'hFFFF_FFFF);
        rd_chk(10'h02A, 32'h43F0_0FFF, "R3 ctrl masked");
        wr(10'h02A, 32'h3C0F_F000);
        rd_chk(10'h02A, 32'h0000_0000, "R3 reserved dropped");

        // R8 LEDs
        wr(10'h000, 32'hFFFF_FFA5);
        check("R8 led pins", {24'd0, led_out}, 32'h0000_00A5);
        rd_chk(10'h000, 32'h0000_00A5, "R8 led readback");

        // R9 DLL
        dll_lock = 8'h0F;
        rd_chk(10'h008, 32'h000F_0001, "R9 mask zero locked");
        wr(10'h008, 32'hFF00_FFFF);
        rd_chk(10'h008, 32'hFF0F_0000, "R9 unlocked selected");
        dll_lock = 8'hFF;
        rd_chk(10'h008, 32'hFFFF_0001, "R9 all locked");
        wr(10'h008, 32'h0F00_0000);
        dll_lock = 8'h0F;
        rd_chk(10'h008, 32'h0F0F_0001, "R9 partial mask");

        // R10 ID and DIP
        rd_chk(10'h004, 32'h4104_1230, "R10 board id");
        rd_chk(10'h005, 32'h0000_0005, "R10 cfg id");
        wr(10'h006, 32'hDEAD_BEEF);
        rd_chk(10'h006, 32'h0220_0000, "R10 aid write ignored");
        wr(10'h002, 32'hFFFF_FFFF);
        rd_chk(10'h002, 32'd0, "R10 dip zero");

        // R11 unmapped
        rd_chk(10'h300, 32'd0, "R11 unmapped read");
        wr(10'h3FF, 32'h0000_0000);
        check("R11 led unchanged", {24'd0, led_out}, 32'h0000_00A5);
        rd_chk(10'h02A, 32'h43F0_0FFF & 32'h3C0F_F000, "R11 ctrl unchanged");

        // R2 data holds without read strobe
        @(negedge clk);
        check("R2 rdata hold", bus_rdata, 32'd0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule